// File: doc/BRIEF.md
# Static Column DRAM Access Sequencer

This block connects a synchronous request port to an asynchronous DRAM that is four bits wide and has nine multiplexed address pins. Each request carries a write flag, an 18-bit address and a 4-bit write nibble, and is taken with a valid/ready handshake. The upper nine address bits select the row and the lower nine select the column. The sequencer drives the row strobe, chip select, write strobe, output enable and the shared address pins. The tristate data bus is split into an outgoing nibble with its enable and an incoming nibble.

The memory does not latch column addresses. For this reason the sequencer holds each column on the pins for the whole of an access. Once a row is open, any number of reads and writes to that row follow one another without closing it. A run of reads keeps chip select low and only moves the column. Every write is an early write: the write strobe is low before chip select falls. A read that follows a write, or a write that follows a read, first puts chip select through a precharge gap.

A request to another row closes the open row and reopens it once the row precharge is done. The row is also closed when the time it has been open comes near its limit. All timings are parameters counted in clock cycles. Read data returns in request order, each nibble marked by a one-cycle valid pulse.

Top module: `scd_seq`

## Requirements
- R1: After synchronous reset, the row strobe, chip select, write strobe and output enable (all active low) are high, the data bus enable and response valid are low, and the port is ready.
- R2: When the row strobe falls, the pins carry request address bits [17:9] (the row). While chip select is low, they carry bits [8:0] (the column).
- R3: Chip select falls only while the row strobe is low, and only after the row strobe has been low for more than T_RCD cycles.
- R4: A request to the open row is served without a row strobe edge. A request to another row makes the row strobe rise and fall again.
- R5: For a write, the write strobe is low for at least one cycle before chip select falls, and output enable stays high. While chip select stays low, the write strobe, column and write nibble do not change.
- R6: Output enable is low only while chip select is low and the write strobe is high. Every read gets exactly one response, marked by a valid pulse one cycle long, in request order.
- R7: Consecutive reads to the open row keep chip select low between them; only the column changes.
- R8: Within one open row, chip select stays high for at least T_CP cycles between two low periods. This covers a read after a write and a write after a read.
- R9: The row strobe stays high for at least T_RP cycles before each falling edge. The reset state counts as precharged.
- R10: The row strobe is never low for T_RAS_MAX cycles or more. An idle open row is closed without any request.
- R11: A read returns the nibble most recently written to the same 18-bit address, or 0 if the address was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Row in [17:9], column in [8:0] |
| req_wdata | input | 4 | Write nibble |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 4 | Read nibble |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Nibble driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Nibble from the memory |

## Verification
The bound checker watches the pin timing rules on every cycle. These are the row-to-select delay, row precharge, the limit on row-open time, write strobe setup before chip select, stability of the column and nibble during a write, the select precharge gap and the single-cycle response pulse. Some properties can only be shown by the bench's scenarios, using a behavioural memory model and a reference store. These are that row hits cause no row strobe edge, that a run of reads uses one chip select fall, that data survives mixed write and read sequences across rows, and that an idle row is closed on its own.

// File: rtl/scd_pkg.sv
package scd_pkg;
    localparam int ROW_W  = 9;
    localparam int COL_W  = 9;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int DQ_W   = 4;
    localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef enum logic [2:0] {
        ST_CLOSED, ST_RCD, ST_SETUP, ST_ACT, ST_CPRE, ST_OPEN
    } seq_state_t;

    typedef struct packed {
        logic             ras_n;
        logic             cs_n;
        logic             we_n;
        logic             oe_n;
        logic [PIN_W-1:0] addr;
    } pins_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   wdata;
    } req_t;

    function automatic logic [PIN_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return PIN_W'(a[ADDR_W-1:COL_W]);
    endfunction

    function automatic logic [PIN_W-1:0] col_of(input logic [ADDR_W-1:0] a);
        return PIN_W'(a[COL_W-1:0]);
    endfunction
endpackage

// File: rtl/scd_phase_timer.sv
module scd_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/scd_row_age.sv
module scd_row_age #(
    parameter int LIMIT = 64,
    parameter int SPAN  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic row_open,
    output logic must_close
);
    localparam int W = $clog2(LIMIT + 1) + 1;

    logic [W-1:0] age_q;

    // age = number of completed cycles with the row strobe low
    always_ff @(posedge clk) begin
        if (rst || !row_open)
            age_q <= '0;
        else if (int'(age_q) < LIMIT)
            age_q <= age_q + 1'b1;
    end

    // one more worst-case operation would reach the limit
    assign must_close = (int'(age_q) + SPAN >= LIMIT);
endmodule

// File: rtl/scd_seq.sv
module scd_seq
    import scd_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_ACT     = 3,
    parameter int T_CP      = 2,
    parameter int T_RP      = 4,
    parameter int T_RAS_MAX = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [DQ_W-1:0]   rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cs_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [PIN_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    // worst-case ras-low cycles spent by one operation started from ST_OPEN
    localparam int SPAN = T_ACT + T_CP + 3;
    localparam int TMAX01 = (T_RCD > T_ACT) ? T_RCD : T_ACT;
    localparam int TMAX23 = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int TMAX   = (TMAX01 > TMAX23) ? TMAX01 : TMAX23;
    localparam int TW     = $clog2(TMAX + 1);

    seq_state_t      state_q, state_d;
    pins_t           pins_q, pins_d;
    req_t            cur_q, cur_d;
    logic [PIN_W-1:0] row_q, row_d;
    logic [DQ_W-1:0] dqo_q, dqo_d, rspd_q, rspd_d;
    logic            dqoe_q, dqoe_d, rspv_q, rspv_d;
    logic            t_load, t_done, age_close, row_hit, accept;
    logic [TW-1:0]   t_val;

    scd_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    scd_row_age #(.LIMIT(T_RAS_MAX), .SPAN(SPAN)) u_age (
        .clk        (clk),
        .rst        (rst),
        .row_open   (!pins_q.ras_n),
        .must_close (age_close)
    );

    assign row_hit = (row_of(req_addr) == row_q);

    always_comb begin
        case (state_q)
            ST_CLOSED: req_ready = t_done;
            ST_OPEN:   req_ready = !age_close && row_hit && (pins_q.cs_n || !req_write);
            default:   req_ready = 1'b0;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        pins_d  = pins_q;
        cur_d   = cur_q;
        row_d   = row_q;
        dqo_d   = dqo_q;
        dqoe_d  = dqoe_q;
        rspv_d  = 1'b0;
        rspd_d  = rspd_q;
        t_load  = 1'b0;
        t_val   = '0;
        case (state_q)
            ST_CLOSED: begin
                if (accept) begin
                    cur_d        = '{wr: req_write, addr: req_addr, wdata: req_wdata};
                    row_d        = row_of(req_addr);
                    pins_d.ras_n = 1'b0;
                    pins_d.addr  = row_of(req_addr);
                    t_load       = 1'b1;
                    t_val        = TW'(T_RCD - 1);
                    state_d      = ST_RCD;
                end
            end
            ST_RCD: begin
                if (t_done) begin
                    pins_d.addr = col_of(cur_q.addr);
                    pins_d.we_n = !cur_q.wr;
                    dqoe_d      = cur_q.wr;
                    dqo_d       = cur_q.wdata;
                    state_d     = ST_SETUP;
                end
            end
            ST_SETUP: begin
                pins_d.cs_n = 1'b0;
                pins_d.oe_n = cur_q.wr;
                t_load      = 1'b1;
                t_val       = TW'(T_ACT - 1);
                state_d     = ST_ACT;
            end
            ST_ACT: begin
                if (t_done) begin
                    if (cur_q.wr) begin
                        pins_d.cs_n = 1'b1;
                        t_load      = 1'b1;
                        t_val       = TW'(T_CP - 1);
                        state_d     = ST_CPRE;
                    end else begin
                        rspv_d  = 1'b1;
                        rspd_d  = dram_dq_in;
                        state_d = ST_OPEN;
                    end
                end
            end
            ST_CPRE: begin
                if (t_done) begin
                    pins_d.we_n = 1'b1;
                    dqoe_d      = 1'b0;
                    state_d     = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (age_close || (req_valid && !row_hit)) begin
                    pins_d.ras_n = 1'b1;
                    pins_d.cs_n  = 1'b1;
                    pins_d.oe_n  = 1'b1;
                    t_load       = 1'b1;
                    t_val        = TW'(T_RP - 1);
                    state_d      = ST_CLOSED;
                end else if (req_valid && req_write && !pins_q.cs_n) begin
                    pins_d.cs_n = 1'b1;
                    pins_d.oe_n = 1'b1;
                    t_load      = 1'b1;
                    t_val       = TW'(T_CP - 1);
                    state_d     = ST_CPRE;
                end else if (accept) begin
                    cur_d       = '{wr: req_write, addr: req_addr, wdata: req_wdata};
                    pins_d.addr = col_of(req_addr);
                    if (req_write) begin
                        pins_d.we_n = 1'b0;
                        dqoe_d      = 1'b1;
                        dqo_d       = req_wdata;
                        state_d     = ST_SETUP;
                    end else if (!pins_q.cs_n) begin
                        t_load  = 1'b1;
                        t_val   = TW'(T_ACT - 1);
                        state_d = ST_ACT;
                    end else begin
                        state_d = ST_SETUP;
                    end
                end
            end
            default: state_d = ST_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLOSED;
            pins_q  <= '{ras_n: 1'b1, cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, addr: '0};
            cur_q   <= '0;
            row_q   <= '0;
            dqo_q   <= '0;
            dqoe_q  <= 1'b0;
            rspv_q  <= 1'b0;
            rspd_q  <= '0;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_d;
            cur_q   <= cur_d;
            row_q   <= row_d;
            dqo_q   <= dqo_d;
            dqoe_q  <= dqoe_d;
            rspv_q  <= rspv_d;
            rspd_q  <= rspd_d;
        end
    end

    assign dram_ras_n  = pins_q.ras_n;
    assign dram_cs_n   = pins_q.cs_n;
    assign dram_we_n   = pins_q.we_n;
    assign dram_oe_n   = pins_q.oe_n;
    assign dram_addr   = pins_q.addr;
    assign dram_dq_out = dqo_q;
    assign dram_dq_oe  = dqoe_q;
    assign rsp_valid   = rspv_q;
    assign rsp_rdata   = rspd_q;
endmodule

// File: rtl/scd_seq_chk.sv
module scd_seq_chk #(
    parameter int T_RCD     = 3,
    parameter int T_CP      = 2,
    parameter int T_RP      = 4,
    parameter int T_RAS_MAX = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       cs_n,
    input logic       we_n,
    input logic       oe_n,
    input logic [8:0] addr,
    input logic [3:0] dq_out,
    input logic       rsp_valid
);
    logic [15:0] hi_cnt, lo_cnt, cs_hi;
    logic        seen_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= 16'(T_RP);
            lo_cnt   <= '0;
            cs_hi    <= '0;
            seen_low <= 1'b0;
        end else begin
            if (ras_n) begin
                if (hi_cnt != 16'hffff) hi_cnt <= hi_cnt + 1'b1;
                lo_cnt   <= '0;
                seen_low <= 1'b0;
            end else begin
                if (lo_cnt != 16'hffff) lo_cnt <= lo_cnt + 1'b1;
                hi_cnt <= '0;
                if (!cs_n) seen_low <= 1'b1;
            end
            if (cs_n) begin
                if (cs_hi != 16'hffff) cs_hi <= cs_hi + 1'b1;
            end else begin
                cs_hi <= '0;
            end
        end
    end

    assert_cs_after_rcd_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (!ras_n && int'(lo_cnt) >= T_RCD));

    assert_ras_precharge_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> int'(hi_cnt) >= T_RP);

    assert_ras_open_limit_R10: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> int'(lo_cnt) < T_RAS_MAX);

    assert_we_setup_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && !we_n) |-> !$past(we_n));

    assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n) && !$past(we_n)) |-> ($stable(we_n) && $stable(addr) && $stable(dq_out)));

    assert_we_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n)) |-> $stable(we_n));

    assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (we_n && !cs_n));

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && seen_low) |-> int'(cs_hi) >= T_CP);
endmodule

bind scd_seq scd_seq_chk #(
    .T_RCD(T_RCD), .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (dram_ras_n),
    .cs_n      (dram_cs_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .addr      (dram_addr),
    .dq_out    (dram_dq_out),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_scd_seq.sv
`timescale 1ns/1ps
module tb_scd_seq;
    localparam int T_RCD = 3, T_ACT = 3, T_CP = 2, T_RP = 4, T_RAS_MAX = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [3:0]  rsp_rdata;
    logic        dram_ras_n, dram_cs_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [8:0]  dram_addr;
    logic [3:0]  dram_dq_out;
    logic [3:0]  dq_in_r = '0;

    always #4 clk = ~clk;

    scd_seq #(.T_RCD(T_RCD), .T_ACT(T_ACT), .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(dram_ras_n), .dram_cs_n(dram_cs_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_r)
    );

    int n_tests = 0, n_fail = 0;
    logic [3:0] mem_m [int];
    logic [3:0] ref_m [int];
    logic [3:0] exp_q [$];
    logic [8:0] row_m = '0, first_row = '0, first_col = '0;
    bit got_row = 0, got_col = 0;
    int ras_falls = 0, cs_falls = 0;
    int hi_run = 0, lo_run = 0, cs_hi_run = 0;
    bit cs_seen = 0, prev_ras = 1, prev_cs = 1, prev_we = 1, prev_rsp = 0;
    logic [8:0] prev_addr = '0;
    logic [3:0] prev_dq = '0;

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic logic [3:0] ref_read(input logic [17:0] a);
        return ref_m.exists(int'(a)) ? ref_m[int'(a)] : 4'h0;
    endfunction

    // pin monitor, memory model and response scoreboard
    always @(negedge clk) begin
        if (rst) begin
            hi_run = T_RP; lo_run = 0; cs_hi_run = 0; cs_seen = 0;
            prev_ras = 1; prev_cs = 1; prev_we = 1; prev_rsp = 0;
        end else begin
            if (prev_ras && !dram_ras_n) begin
                chk(hi_run >= T_RP, "R9 ras precharge", hi_run, T_RP);
                row_m = dram_addr;
                ras_falls++;
                if (!got_row) begin got_row = 1; first_row = dram_addr; end
            end
            if (!prev_ras && dram_ras_n)
                chk(lo_run < T_RAS_MAX, "R10 ras low time", lo_run, T_RAS_MAX - 1);
            if (prev_cs && !dram_cs_n) begin
                chk(!dram_ras_n && lo_run > T_RCD, "R3 ras to cs delay", lo_run, T_RCD + 1);
                if (cs_seen) chk(cs_hi_run >= T_CP, "R8 cs precharge", cs_hi_run, T_CP);
                if (!dram_we_n) begin
                    chk(!prev_we, "R5 we setup", int'(prev_we), 0);
                    chk(dram_oe_n && dram_dq_oe, "R5 oe high in write", int'(dram_oe_n), 1);
                    mem_m[int'({row_m, dram_addr})] = dram_dq_out;
                end
                cs_falls++;
                if (!got_col) begin got_col = 1; first_col = dram_addr; end
            end
            if (!prev_cs && !dram_cs_n && !prev_we)
                chk(!dram_we_n && dram_addr == prev_addr && dram_dq_out == prev_dq,
                    "R5 write hold", int'(dram_addr), int'(prev_addr));
            if (!dram_oe_n)
                chk(dram_we_n && !dram_cs_n, "R6 oe only in read", int'(dram_we_n), 1);
            if (rsp_valid) begin
                chk(!prev_rsp, "R6 single pulse", int'(prev_rsp), 0);
                if (exp_q.size() == 0)
                    chk(0, "R6 unexpected response", 1, 0);
                else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R11 read data", int'(rsp_rdata), int'(e));
                end
            end
            if (dram_ras_n) begin hi_run++; lo_run = 0; cs_seen = 0; end
            else begin lo_run++; hi_run = 0; end
            if (dram_cs_n) cs_hi_run++;
            else begin cs_hi_run = 0; if (!dram_ras_n) cs_seen = 1; end
            prev_ras = dram_ras_n; prev_cs = dram_cs_n; prev_we = dram_we_n;
            prev_rsp = rsp_valid; prev_addr = dram_addr; prev_dq = dram_dq_out;
        end
        dq_in_r = (!dram_cs_n && mem_m.exists(int'({row_m, dram_addr})))
                  ? mem_m[int'({row_m, dram_addr})] : 4'h0;
    end

    task automatic send(input bit w, input logic [17:0] a, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        if (w) ref_m[int'(a)] = d;
        else exp_q.push_back(ref_read(a));
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(dram_ras_n && dram_cs_n && dram_we_n && dram_oe_n, "R1 strobes high", 0, 1);
        chk(!dram_dq_oe && !rsp_valid, "R1 bus and response idle", int'(dram_dq_oe), 0);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

        // directed: row hits, static column reads, write then read
        send(0, {9'd5, 9'd1}, 4'h0);
        send(0, {9'd5, 9'd2}, 4'h0);
        send(1, {9'd5, 9'd3}, 4'hA);
        send(0, {9'd5, 9'd3}, 4'h0);
        idle(20);
        chk(first_row == 9'd5, "R2 row on pins", int'(first_row), 5);
        chk(first_col == 9'd1, "R2 column on pins", int'(first_col), 1);
        chk(ras_falls == 1, "R4 row hit keeps row open", ras_falls, 1);
        chk(cs_falls == 3, "R7 R8 cs falls for read,read,write,read", cs_falls, 3);
        chk(!dram_ras_n, "R4 row still open", int'(dram_ras_n), 0);

        // row miss
        send(0, {9'd6, 9'd3}, 4'h0);
        idle(20);
        chk(ras_falls == 2, "R4 row miss reopens", ras_falls, 2);

        // idle row closes on its own
        idle(T_RAS_MAX + 20);
        chk(dram_ras_n, "R10 idle row closed", int'(dram_ras_n), 1);

        // random mix over a few rows
        for (int i = 0; i < 400; i++) begin
            logic [8:0] r;
            r = 9'(($urandom % 3) * 97 + 2);
            send(($urandom % 2) == 1, {r, 9'($urandom % 8)}, 4'($urandom));
            if (($urandom % 8) == 0) idle($urandom % 4);
        end
        idle(200);
        chk(exp_q.size() == 0, "R6 every read answered", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule